// File: doc/BRIEF.md
# Multi-Rail Power-Good Aggregator

This block turns the status of four regulator rails into one power-good pin. Each rail supplies an enable, a lifecycle phase, undervoltage, overvoltage and current-limit comparator flags, and a flag that is set while a protection shutdown is still pending. Per-rail logic decides whether the rail is good. The decision depends on that rail's monitoring selection, its enable, its phase and the comparator flags.

Each rail's decision is then filtered. Going bad has its own filter time, and going good has a filter time chosen by a control bit. The filtered results are ANDed together. The pin driver then applies the programmed polarity and drive type, either push-pull or open-drain.

A small register port holds the monitoring selection and the control bits. It also exposes a per-rail fault register. A read of that register clears only the bits whose rail is good again. A sticky option keeps the pin inactive until software has read out every pending fault bit.

Top module: `pgood_aggregator`

## Requirements
- R1: Each rail has a 2-bit monitor field in register address 0, at bits [2i+1:2i] for rail i. Value 00 makes the rail always good, whatever its other inputs. Value 01 checks voltage only, so the current-limit flag is ignored. Values 10 and 11 also treat an active current-limit flag as bad.
- R2: A rail whose enable is 0 counts as good, unless its protection-pending flag is set.
- R3: Phase codes are 0 start-up delay, 1 soft start, 2 ramp-up, 3 regulating, 4 ramp after a setpoint change, 5 shutdown delay, 6 ramp-down and 7 idle. Codes 0, 1, 2 and 4 make a monitored, enabled rail bad. Codes 5, 6 and 7 make it good. Code 3 applies the comparator checks.
- R4: A monitored rail with its protection-pending flag set is bad, whatever its enable and phase.
- R5: Control bit 0 (window) chooses the voltage checks. When it is 0, only undervoltage makes the rail bad. When it is 1, overvoltage does as well.
- R6: The combined power-good is true only when every filtered rail is good.
- R7: A rail turns bad only after its raw status has been bad for INV_FILT consecutive cycles. The pin changes on the next clock edge after that. A shorter bad pulse has no effect on the pin.
- R8: A rail turns good after SHORT_FILT good cycles when control bit 1 is 0, and after LONG_FILT good cycles when it is 1.
- R9: Fault bit i at address 2 is set while rail i is filtered bad. A read of address 2 returns the fault bits on reg_rdata in the following cycle. The same read clears every bit whose rail is filtered good, and leaves set the bits of rails that are still bad.
- R10: When control bit 2 (sticky) is 1, the pin stays inactive while any fault bit is set, even if all rails are good.
- R11: Control bit 3 inverts the pin level, making it low when good. When control bit 4 is 1, the pin is open-drain: pg_out is 0, and pg_oe is 1 only when the level must be low. When control bit 4 is 0, pg_oe is always 1 and pg_out carries the level.
- R12: Address 0 reads back the monitor field. Address 1 reads back the five control bits and returns zero above them. Both reset to 0.
- R13: After reset the pin is driven high (the good level) in push-pull mode and the fault register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_en | input | NUM_RAILS | Per-rail enable |
| rail_phase | input | 3*NUM_RAILS | Per-rail phase code, rail i at [3i+2:3i] |
| rail_uv | input | NUM_RAILS | Undervoltage comparator flags |
| rail_ov | input | NUM_RAILS | Overvoltage comparator flags |
| rail_ilim | input | NUM_RAILS | Current-limit flags |
| rail_prot | input | NUM_RAILS | Protection shutdown pending flags |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid the cycle after reg_rd |
| pg_out | output | 1 | Pin data |
| pg_oe | output | 1 | Pin driver enable |

## Verification
A rail filter that holds a wrong count shows up at the pins as a power-good edge one or more cycles away from the INV_FILT+1 or SHORT_FILT+1 edge. The bench measures those edges to the exact cycle. A fault register that clears the wrong bit appears in the value returned by the next read of address 2, one cycle after the strobe. In sticky mode the same error also appears as a pin that recovers too early or never. A wrong monitor-select or phase decode shows in the settled pin level within one filter period of the stimulus.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

  typedef enum logic [2:0] {
    PH_STARTUP_DLY = 3'd0,
    PH_SOFT_START  = 3'd1,
    PH_RAMP_UP     = 3'd2,
    PH_REGULATE    = 3'd3,
    PH_VSET_RAMP   = 3'd4,
    PH_SHUT_DLY    = 3'd5,
    PH_RAMP_DOWN   = 3'd6,
    PH_IDLE        = 3'd7
  } rail_phase_e;

  typedef struct packed {
    logic od;
    logic invert;
    logic sticky;
    logic long_valid;
    logic window;
  } pg_ctrl_t;

  localparam int unsigned CTRL_W    = 5;
  localparam int unsigned PHASE_W   = 3;
  localparam int unsigned ADDR_W    = 2;
  localparam logic [1:0]  SEL_OFF   = 2'b00;
  localparam logic [1:0]  ADDR_SEL  = 2'd0;
  localparam logic [1:0]  ADDR_CTRL = 2'd1;
  localparam logic [1:0]  ADDR_FLT  = 2'd2;

endpackage

// File: rtl/pgood_rail_eval.sv
module pgood_rail_eval
  import pgood_pkg::*;
(
  input  logic [1:0]         mon_sel,
  input  logic               window,
  input  logic               en,
  input  logic [PHASE_W-1:0] phase,
  input  logic               uv,
  input  logic               ov,
  input  logic               ilim,
  input  logic               prot,
  output logic               raw_good
);

  logic combined;
  logic volt_ok;

  assign combined = mon_sel[1];
  assign volt_ok  = !uv && !(window && ov);

  always_comb begin
    raw_good = 1'b1;
    if (mon_sel == SEL_OFF) begin
      raw_good = 1'b1;
    end else if (prot) begin
      raw_good = 1'b0;
    end else if (!en) begin
      raw_good = 1'b1;
    end else begin
      case (rail_phase_e'(phase))
        PH_STARTUP_DLY,
        PH_SOFT_START,
        PH_RAMP_UP,
        PH_VSET_RAMP:  raw_good = 1'b0;
        PH_REGULATE:   raw_good = volt_ok && !(combined && ilim);
        PH_SHUT_DLY,
        PH_RAMP_DOWN,
        PH_IDLE:       raw_good = 1'b1;
        default:       raw_good = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/pgood_debounce.sv
module pgood_debounce #(
  parameter int unsigned INV_FILT   = 70,
  parameter int unsigned SHORT_FILT = 70,
  parameter int unsigned LONG_FILT  = 1100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_good,
  input  logic long_sel,
  output logic filt_good
);

  localparam int unsigned MAX_A = (INV_FILT > SHORT_FILT) ? INV_FILT : SHORT_FILT;
  localparam int unsigned MAX_L = (MAX_A > LONG_FILT) ? MAX_A : LONG_FILT;
  localparam int unsigned CNT_W = $clog2(MAX_L + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             filt_q, filt_d;
  logic             differ, hit;

  always_comb begin
    differ = raw_good ^ filt_q;
    if (filt_q)        lim = CNT_W'(INV_FILT);
    else if (long_sel) lim = CNT_W'(LONG_FILT);
    else               lim = CNT_W'(SHORT_FILT);
    hit    = differ && (cnt_q == lim - 1'b1);
    filt_d = hit ? raw_good : filt_q;
    cnt_d  = (!differ || hit) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt_good = filt_q;

endmodule

// File: rtl/pgood_csr.sv
module pgood_csr
  import pgood_pkg::*;
#(
  parameter int unsigned NUM_RAILS = 4,
  parameter int unsigned REG_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [REG_W-1:0]       wdata,
  input  logic [NUM_RAILS-1:0]   filt_good,
  output logic [2*NUM_RAILS-1:0] mon_sel,
  output pg_ctrl_t               ctrl,
  output logic [NUM_RAILS-1:0]   fault,
  output logic [REG_W-1:0]       rdata
);

  localparam int unsigned SEL_W = 2 * NUM_RAILS;

  logic [SEL_W-1:0]     sel_q, sel_d;
  pg_ctrl_t             ctrl_q, ctrl_d;
  logic [NUM_RAILS-1:0] flt_q, flt_d, flt_clr, flt_set;
  logic [REG_W-1:0]     rdata_q, rdata_d;
  logic                 rd_flt;

  always_comb begin
    sel_d   = sel_q;
    ctrl_d  = ctrl_q;
    if (wr && addr == ADDR_SEL)  sel_d  = wdata[SEL_W-1:0];
    if (wr && addr == ADDR_CTRL) ctrl_d = pg_ctrl_t'(wdata[CTRL_W-1:0]);

    rd_flt  = rd && (addr == ADDR_FLT);
    flt_set = ~filt_good;
    flt_clr = rd_flt ? filt_good : '0;
    flt_d   = (flt_q & ~flt_clr) | flt_set;

    rdata_d = rdata_q;
    if (rd) begin
      case (addr)
        ADDR_SEL:  rdata_d = REG_W'(sel_q);
        ADDR_CTRL: rdata_d = REG_W'(ctrl_q);
        ADDR_FLT:  rdata_d = REG_W'(flt_q);
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      ctrl_q  <= '0;
      flt_q   <= '0;
      rdata_q <= '0;
    end else begin
      sel_q   <= sel_d;
      ctrl_q  <= ctrl_d;
      flt_q   <= flt_d;
      rdata_q <= rdata_d;
    end
  end

  assign mon_sel = sel_q;
  assign ctrl    = ctrl_q;
  assign fault   = flt_q;
  assign rdata   = rdata_q;

endmodule

// File: rtl/pgood_pin_drv.sv
module pgood_pin_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic good_d,
  input  logic invert,
  input  logic od,
  output logic good_q,
  output logic pin_out,
  output logic pin_oe
);

  logic good_r;
  logic level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_r <= 1'b1;
    else        good_r <= good_d;
  end

  always_comb begin
    level   = good_r ^ invert;
    pin_out = od ? 1'b0 : level;
    pin_oe  = od ? !level : 1'b1;
  end

  assign good_q = good_r;

endmodule

// File: rtl/pgood_aggregator.sv
module pgood_aggregator
  import pgood_pkg::*;
#(
  parameter int unsigned NUM_RAILS  = 4,
  parameter int unsigned REG_W      = 8,
  parameter int unsigned INV_FILT   = 70,
  parameter int unsigned SHORT_FILT = 70,
  parameter int unsigned LONG_FILT  = 1100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_RAILS-1:0]         rail_en,
  input  logic [PHASE_W*NUM_RAILS-1:0] rail_phase,
  input  logic [NUM_RAILS-1:0]         rail_uv,
  input  logic [NUM_RAILS-1:0]         rail_ov,
  input  logic [NUM_RAILS-1:0]         rail_ilim,
  input  logic [NUM_RAILS-1:0]         rail_prot,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  output logic [REG_W-1:0]             reg_rdata,
  output logic                         pg_out,
  output logic                         pg_oe
);

  localparam int unsigned SEL_W = 2 * NUM_RAILS;

  logic                 rst_meta_n, rst_sync_n;
  logic [NUM_RAILS-1:0] raw_good, filt_good, fault_q;
  logic [SEL_W-1:0]     mon_sel;
  pg_ctrl_t             ctrl_q;
  logic                 all_good, pg_state, pg_good_q;
  logic                 unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  generate
    if (REG_W > SEL_W) begin : g_spare
      assign unused_wbits = ^reg_wdata[REG_W-1:SEL_W];
    end else begin : g_nospare
      assign unused_wbits = 1'b0;
    end
  endgenerate

  pgood_csr #(.NUM_RAILS(NUM_RAILS), .REG_W(REG_W)) csr_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (reg_wr),
    .rd        (reg_rd),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .filt_good (filt_good),
    .mon_sel   (mon_sel),
    .ctrl      (ctrl_q),
    .fault     (fault_q),
    .rdata     (reg_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      pgood_rail_eval eval_i (
        .mon_sel  (mon_sel[2*i +: 2]),
        .window   (ctrl_q.window),
        .en       (rail_en[i]),
        .phase    (rail_phase[PHASE_W*i +: PHASE_W]),
        .uv       (rail_uv[i]),
        .ov       (rail_ov[i]),
        .ilim     (rail_ilim[i]),
        .prot     (rail_prot[i]),
        .raw_good (raw_good[i])
      );

      pgood_debounce #(
        .INV_FILT  (INV_FILT),
        .SHORT_FILT(SHORT_FILT),
        .LONG_FILT (LONG_FILT)
      ) deb_i (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .raw_good  (raw_good[i]),
        .long_sel  (ctrl_q.long_valid),
        .filt_good (filt_good[i])
      );
    end
  endgenerate

  always_comb begin
    all_good = &filt_good;
    pg_state = all_good && !(ctrl_q.sticky && (|fault_q));
  end

  pgood_pin_drv pin_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .good_d  (pg_state),
    .invert  (ctrl_q.invert),
    .od      (ctrl_q.od),
    .good_q  (pg_good_q),
    .pin_out (pg_out),
    .pin_oe  (pg_oe)
  );

endmodule

// File: rtl/pgood_aggregator_chk.sv
module pgood_aggregator_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] raw_good,
  input logic [N-1:0] filt_good,
  input logic [N-1:0] fault_q,
  input logic         pg_good_q,
  input logic         sticky,
  input logic         od,
  input logic         pg_out,
  input logic         pg_oe
);

  // R7: a filtered rail only flips after its raw status disagreed
  assert_filter_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_good ^ $past(filt_good)) & ~$past(raw_good ^ filt_good)) == '0);

  // R6: combined good rises only after every filtered rail was good
  assert_all_rails_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_good_q) |-> $past(&filt_good));

  // R9: a filtered-bad rail has its fault bit set on the next cycle
  assert_fault_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (~filt_good != '0) |=> ((fault_q & ~$past(filt_good)) == ~$past(filt_good)));

  // R10: pending faults in sticky mode hold the output inactive
  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && (|fault_q)) |=> !pg_good_q);

  // R11: open-drain only ever drives low
  assert_od_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (od && pg_oe) |-> !pg_out);

  // R11: push-pull always drives
  assert_pp_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !od |-> pg_oe);

endmodule

bind pgood_aggregator pgood_aggregator_chk #(.N(NUM_RAILS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .raw_good  (raw_good),
  .filt_good (filt_good),
  .fault_q   (fault_q),
  .pg_good_q (pg_good_q),
  .sticky    (ctrl_q.sticky),
  .od        (ctrl_q.od),
  .pg_out    (pg_out),
  .pg_oe     (pg_oe)
);

// File: tb/pgood_aggregator_tb.sv
`timescale 1ns/1ps
module pgood_aggregator_tb_top;

  localparam int unsigned INV   = 3;
  localparam int unsigned SHORT = 5;
  localparam int unsigned LONG  = 12;
  localparam int unsigned NV    = 19;

  typedef struct packed {
    logic [3:0]  en;
    logic [11:0] ph;
    logic [3:0]  uv;
    logic [3:0]  ov;
    logic [3:0]  il;
    logic [3:0]  pr;
    logic [7:0]  sel;
    logic [7:0]  ctrl;
    logic        good;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'hF, 12'h6DB, 4'h0, 4'h0, 4'h0, 4'h0, 8'h55, 8'h00, 1'b1}, // R6 all clean
    '{4'hF, 12'h6DB, 4'h4, 4'h0, 4'h0, 4'h0, 8'h55, 8'h00, 1'b0}, // R5 uv
    '{4'hF, 12'h6DB, 4'h0, 4'h2, 4'h0, 4'h0, 8'h55, 8'h00, 1'b1}, // R5 ov ignored
    '{4'hF, 12'h6DB, 4'h0, 4'h2, 4'h0, 4'h0, 8'h55, 8'h01, 1'b0}, // R5 ov window
    '{4'hF, 12'h6DB, 4'h0, 4'h0, 4'h1, 4'h0, 8'h55, 8'h00, 1'b1}, // R1 voltage only
    '{4'hF, 12'h6DB, 4'h0, 4'h0, 4'h1, 4'h0, 8'h56, 8'h00, 1'b0}, // R1 sel 10
    '{4'hF, 12'h6DB, 4'h0, 4'h0, 4'h1, 4'h0, 8'h57, 8'h00, 1'b0}, // R1 sel 11
    '{4'hF, 12'h6DB, 4'h8, 4'h0, 4'h0, 4'h0, 8'h15, 8'h00, 1'b1}, // R1 excluded
    '{4'h7, 12'h6DB, 4'h8, 4'h0, 4'h0, 4'h0, 8'h55, 8'h00, 1'b1}, // R2 disabled
    '{4'h7, 12'h6DB, 4'h0, 4'h0, 4'h0, 4'h8, 8'h55, 8'h00, 1'b0}, // R4 prot
    '{4'hF, 12'h6C3, 4'h0, 4'h0, 4'h0, 4'h0, 8'h55, 8'h00, 1'b0}, // R3 startup
    '{4'hF, 12'h6CB, 4'h0, 4'h0, 4'h0, 4'h0, 8'h55, 8'h00, 1'b0}, // R3 soft
    '{4'hF, 12'h6D3, 4'h0, 4'h0, 4'h0, 4'h0, 8'h55, 8'h00, 1'b0}, // R3 ramp up
    '{4'hF, 12'h6E3, 4'h0, 4'h0, 4'h0, 4'h0, 8'h55, 8'h00, 1'b0}, // R3 vset ramp
    '{4'hF, 12'h6EB, 4'h2, 4'h0, 4'h0, 4'h0, 8'h55, 8'h00, 1'b1}, // R3 shut delay
    '{4'hF, 12'h6F3, 4'h2, 4'h0, 4'h0, 4'h0, 8'h55, 8'h00, 1'b1}, // R3 ramp down
    '{4'hF, 12'h6FB, 4'h2, 4'h0, 4'h0, 4'h0, 8'h55, 8'h00, 1'b1}, // R3 idle
    '{4'hF, 12'h6F3, 4'h0, 4'h0, 4'h0, 4'h2, 8'h55, 8'h00, 1'b0}, // R4 prot in ramp down
    '{4'hF, 12'h6DB, 4'h0, 4'h0, 4'h0, 4'h2, 8'h51, 8'h00, 1'b1}  // R1 excluded beats prot
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rail_en, rail_uv, rail_ov, rail_ilim, rail_prot;
  logic [11:0] rail_phase;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata, rv;
  logic        pg_out, pg_oe;
  int          n_run = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  pgood_aggregator #(
    .NUM_RAILS(4), .REG_W(8), .INV_FILT(INV), .SHORT_FILT(SHORT), .LONG_FILT(LONG)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .rail_phase(rail_phase),
    .rail_uv(rail_uv), .rail_ov(rail_ov), .rail_ilim(rail_ilim), .rail_prot(rail_prot),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pg_out(pg_out), .pg_oe(pg_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rail_en = 4'hF; rail_phase = 12'h6DB;
    rail_uv = '0; rail_ov = '0; rail_ilim = '0; rail_prot = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R13 reset state
    check("R13 reset pg_out", pg_out, 1);
    check("R13 reset pg_oe", pg_oe, 1);
    reg_read(2'd2, rv); check("R13 reset fault", rv, 8'h00);
    reg_read(2'd0, rv); check("R12 reset sel", rv, 8'h00);
    reg_read(2'd1, rv); check("R12 reset ctrl", rv, 8'h00);

    // R12 readback
    reg_write(2'd1, 8'hE0); reg_read(2'd1, rv); check("R12 ctrl upper bits zero", rv, 8'h00);
    reg_write(2'd0, 8'hA6); reg_read(2'd0, rv); check("R12 sel readback", rv, 8'hA6);
    reg_write(2'd0, 8'h55); tick(LONG + 4);

    // Table walk: R1/R2/R3/R4/R5/R6
    for (int v = 0; v < NV; v++) begin
      reg_write(2'd0, VECS[v].sel);
      reg_write(2'd1, VECS[v].ctrl);
      rail_en = VECS[v].en; rail_phase = VECS[v].ph;
      rail_uv = VECS[v].uv; rail_ov = VECS[v].ov;
      rail_ilim = VECS[v].il; rail_prot = VECS[v].pr;
      tick(LONG + INV + 4);
      check($sformatf("R1/R2/R3/R4/R5/R6 vector %0d pg_out", v), pg_out, VECS[v].good);
      reg_read(2'd2, rv);
    end

    // Back to clean state
    rail_en = 4'hF; rail_phase = 12'h6DB;
    rail_uv = '0; rail_ov = '0; rail_ilim = '0; rail_prot = '0;
    reg_write(2'd0, 8'h55); reg_write(2'd1, 8'h00);
    tick(LONG + 4);
    reg_read(2'd2, rv);
    tick(2);
    check("R6 clean restore", pg_out, 1);

    // R7 invalid filter timing
    rail_uv = 4'h1;
    tick(INV);     check("R7 no change before filter", pg_out, 1);
    tick(1);       check("R7 pin falls at INV+1", pg_out, 0);
    // R8 short valid filter
    rail_uv = 4'h0;
    tick(SHORT);   check("R8 short still low", pg_out, 0);
    tick(1);       check("R8 short rises", pg_out, 1);
    // R7 glitch shorter than filter ignored
    rail_uv = 4'h1; tick(INV - 1); rail_uv = 4'h0;
    tick(1);       check("R7 glitch ignored a", pg_out, 1);
    tick(6);       check("R7 glitch ignored b", pg_out, 1);
    // R8 long valid filter
    reg_write(2'd1, 8'h02);
    rail_uv = 4'h1; tick(INV + 3);
    rail_uv = 4'h0;
    tick(LONG);    check("R8 long still low", pg_out, 0);
    tick(1);       check("R8 long rises", pg_out, 1);
    reg_write(2'd1, 8'h00);

    // R9 fault clear on read
    reg_read(2'd2, rv);
    reg_read(2'd2, rv); check("R9 fault cleared", rv, 8'h00);
    rail_uv = 4'h4; tick(INV + 3);
    reg_read(2'd2, rv); check("R9 fault set rail2", rv, 8'h04);
    reg_read(2'd2, rv); check("R9 bad rail kept", rv, 8'h04);
    rail_uv = 4'h0; tick(SHORT + 3);
    reg_read(2'd2, rv); check("R9 pending after recovery", rv, 8'h04);
    reg_read(2'd2, rv); check("R9 cleared by read", rv, 8'h00);

    // R10 sticky
    reg_write(2'd1, 8'h04);
    rail_uv = 4'h1; tick(INV + 3);
    rail_uv = 4'h0; tick(SHORT + 5);
    check("R10 sticky holds low", pg_out, 0);
    reg_read(2'd2, rv); check("R10 fault pending", rv, 8'h01);
    tick(2);
    check("R10 released after read", pg_out, 1);

    // R11 polarity and drive type
    reg_write(2'd1, 8'h08); tick(2);
    check("R11 inverted out", pg_out, 0);
    check("R11 inverted oe", pg_oe, 1);
    reg_write(2'd1, 8'h10); tick(2);
    check("R11 od released", {pg_oe, pg_out}, 2'b00);
    reg_write(2'd1, 8'h18); tick(2);
    check("R11 od inverted drives low", {pg_oe, pg_out}, 2'b10);
    reg_write(2'd1, 8'h10);
    rail_uv = 4'h8; tick(INV + 3);
    check("R11 od bad drives low", {pg_oe, pg_out}, 2'b10);
    rail_uv = 4'h0; tick(SHORT + 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule